// File: doc/BRIEF.md
# Block-Aligned Multi-Instruction Fetch Stage

This block is the fetch stage of a superscalar front end. It presents its fetch address to the instruction cache. Each cycle it takes back the returned cache block and produces a group of up to `FETCH_W` sequential 4-byte instructions. The group starts at the word the address selects inside the block. It never crosses into the next block, so an address on the last word of a block yields a single instruction. The group also ends on the first slot that the branch predictor marks as taken. The predictor supplies one taken flag per slot and a single target per cycle.

The next fetch address is the predicted target when a taken slot closed the group. Otherwise it is the group start plus four bytes per delivered instruction. A redirect from later pipeline stages overrides everything. A cache miss delivers nothing and retries the same address. A stalled consumer freezes both the address and the delivered bundle.

Top module: `fetch_group_unit`

## Requirements
- R1: While and right after reset, `fetch_pc` equals `RESET_PC` and `out_valid` is all zero.
- R2: On an accepted hit, `out_valid` has its low n bits set and the rest clear. n = min(`FETCH_W`, words left in the block from the word offset `fetch_pc[OFF_W+1:2]`, index of the lowest taken slot + 1). Slot i of `pred_taken` refers to the word at offset + i, and flags at slots beyond the other two limits are ignored.
- R3: Slot i of `out_insn` (bits i*32 up to i*32+31) carries block word offset+i, where block word k sits at `cache_block` bits k*32 up to k*32+31. Invalid slots read zero. `out_pc` gives the address of slot 0.
- R4: A fetch whose word offset is the last word of the block delivers exactly one instruction (`out_valid` = 1).
- R5: When a taken slot ends the group, the next `fetch_pc` is `pred_target` with its low two bits cleared.
- R6: When no taken slot ends the group, the next `fetch_pc` is the old one plus 4 × n.
- R7: With `out_ready` low and no redirect, `fetch_pc`, `out_valid`, `out_insn` and `out_pc` keep their values.
- R8: `redirect_valid` high loads `fetch_pc` with `redirect_pc` (low two bits cleared) and clears `out_valid` on the next edge, whatever `out_ready` and `cache_hit` are.
- R9: With `out_ready` high, no redirect and `cache_hit` low, `out_valid` clears and `fetch_pc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Later-stage redirect request |
| redirect_pc | input | ADDR_W | Redirect address |
| fetch_pc | output | ADDR_W | Current fetch address sent to the cache |
| cache_hit | input | 1 | Cache block below is valid for `fetch_pc` |
| cache_block | input | WORDS*32 | Whole cache block, word k at bits k*32 upward |
| pred_taken | input | FETCH_W | Per-slot predicted-taken flags |
| pred_target | input | ADDR_W | Predicted target for this cycle |
| out_ready | input | 1 | Consumer accepts a new group |
| out_valid | output | FETCH_W | Per-slot valid, contiguous from slot 0 |
| out_insn | output | FETCH_W*32 | Delivered instructions |
| out_pc | output | ADDR_W | Address of slot 0 of the delivered group |

## Verification
`fetch_pc` follows the state register directly, so a new address shows up one rising edge after the inputs that chose it. The bundle outputs (`out_valid`, `out_insn`, `out_pc`) are registered and also change exactly one edge after the cache data and predictions they were built from. The bench drives every input at the falling edge. It compares all outputs at the next falling edge, against a model advanced once per driven cycle, so each comparison sees exactly one rising edge. The checker's properties use a one-cycle `|=>` window and do the same.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int INSN_W     = 32;
  localparam int INSN_SHIFT = 2;

  typedef enum logic [1:0] {
    ACT_HOLD     = 2'd0,
    ACT_REDIRECT = 2'd1,
    ACT_MISS     = 2'd2,
    ACT_ISSUE    = 2'd3
  } fetch_act_e;
endpackage

// File: rtl/fetch_group_sizer.sv
module fetch_group_sizer #(
  parameter int FETCH_W = 4,
  parameter int WORDS   = 8,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
  input  logic [OFF_W-1:0]   offset,
  input  logic [FETCH_W-1:0] taken,
  output logic [CNT_W-1:0]   count,
  output logic               taken_end,
  output logic [FETCH_W-1:0] mask
);
  // words available before the block boundary, capped by the fetch width
  function automatic int slot_limit(input logic [OFF_W-1:0] off);
    int room;
    room = WORDS - int'(off);
    return (room < FETCH_W) ? room : FETCH_W;
  endfunction

  int n;
  int lim;
  logic te;

  always_comb begin
    lim = slot_limit(offset);
    n   = lim;
    te  = 1'b0;
    // descending scan so the lowest taken slot has the final word
    for (int i = FETCH_W - 1; i >= 0; i--) begin
      if (i < lim && taken[i]) begin
        n  = i + 1;
        te = 1'b1;
      end
    end
    for (int i = 0; i < FETCH_W; i++) mask[i] = (i < n);
  end

  assign count     = CNT_W'(n);
  assign taken_end = te;
endmodule

// File: rtl/fetch_slot_select.sv
module fetch_slot_select #(
  parameter int FETCH_W = 4,
  parameter int WORDS   = 8,
  parameter int INSN_W  = 32,
  localparam int OFF_W  = $clog2(WORDS)
) (
  input  logic [OFF_W-1:0]          offset,
  input  logic [WORDS*INSN_W-1:0]   block,
  input  logic [FETCH_W-1:0]        mask,
  output logic [FETCH_W*INSN_W-1:0] insn
);
  for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
    logic [INSN_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < WORDS; k++) begin
        if (int'(offset) + s == k) pick = block[k*INSN_W +: INSN_W];
      end
    end
    assign insn[s*INSN_W +: INSN_W] = mask[s] ? pick : '0;
  end
endmodule

// File: rtl/fetch_group_unit.sv
module fetch_group_unit
  import fetch_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WORDS    = 8,
  parameter int          FETCH_W  = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       redirect_valid,
  input  logic [ADDR_W-1:0]          redirect_pc,
  output logic [ADDR_W-1:0]          fetch_pc,
  input  logic                       cache_hit,
  input  logic [WORDS*INSN_W-1:0]    cache_block,
  input  logic [FETCH_W-1:0]         pred_taken,
  input  logic [ADDR_W-1:0]          pred_target,
  input  logic                       out_ready,
  output logic [FETCH_W-1:0]         out_valid,
  output logic [FETCH_W*INSN_W-1:0]  out_insn,
  output logic [ADDR_W-1:0]          out_pc
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int CNT_W = $clog2(FETCH_W + 1);
  localparam logic [ADDR_W-1:0] AMASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0]         pc_q;
  logic [OFF_W-1:0]          grp_offset;
  logic [CNT_W-1:0]          grp_count;
  logic                      grp_taken_end;
  logic [FETCH_W-1:0]        grp_mask;
  logic [FETCH_W*INSN_W-1:0] grp_insn;
  logic [ADDR_W-1:0]         next_pc;
  fetch_act_e                act;
  logic                      issue;

  assign grp_offset = pc_q[OFF_W+INSN_SHIFT-1:INSN_SHIFT];

  fetch_group_sizer #(.FETCH_W(FETCH_W), .WORDS(WORDS)) u_sizer (
    .offset    (grp_offset),
    .taken     (pred_taken),
    .count     (grp_count),
    .taken_end (grp_taken_end),
    .mask      (grp_mask)
  );

  fetch_slot_select #(.FETCH_W(FETCH_W), .WORDS(WORDS), .INSN_W(INSN_W)) u_select (
    .offset (grp_offset),
    .block  (cache_block),
    .mask   (grp_mask),
    .insn   (grp_insn)
  );

  always_comb begin
    if (redirect_valid)  act = ACT_REDIRECT;
    else if (!out_ready) act = ACT_HOLD;
    else if (!cache_hit) act = ACT_MISS;
    else                 act = ACT_ISSUE;
  end

  assign issue   = (act == ACT_ISSUE);
  assign next_pc = grp_taken_end ? (pred_target & AMASK)
                                 : pc_q + (ADDR_W'(grp_count) << INSN_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= ADDR_W'(RESET_PC);
      out_valid <= '0;
      out_insn  <= '0;
      out_pc    <= '0;
    end else begin
      case (act)
        ACT_REDIRECT: begin
          pc_q      <= redirect_pc & AMASK;
          out_valid <= '0;
        end
        ACT_MISS: out_valid <= '0;
        ACT_ISSUE: begin
          pc_q      <= next_pc;
          out_valid <= grp_mask;
          out_insn  <= grp_insn;
          out_pc    <= pc_q;
        end
        default: ;
      endcase
    end
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/fetch_group_unit_chk.sv
module fetch_group_unit_chk #(
  parameter int ADDR_W  = 32,
  parameter int WORDS   = 8,
  parameter int FETCH_W = 4,
  parameter int INSN_W  = 32,
  localparam int OFF_W  = $clog2(WORDS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      redirect_valid,
  input logic [ADDR_W-1:0]         redirect_pc,
  input logic                      cache_hit,
  input logic                      out_ready,
  input logic [ADDR_W-1:0]         pred_target,
  input logic [ADDR_W-1:0]         fetch_pc,
  input logic [FETCH_W-1:0]        out_valid,
  input logic [FETCH_W*INSN_W-1:0] out_insn,
  input logic [ADDR_W-1:0]         out_pc,
  input logic                      issue,
  input logic                      grp_taken_end,
  input logic [OFF_W-1:0]          grp_offset
);
  localparam logic [ADDR_W-1:0] AMASK = ~ADDR_W'(3);
  localparam logic [OFF_W-1:0]  LAST  = OFF_W'(WORDS - 1);

  p_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & (out_valid + FETCH_W'(1))) == '0);

  p_slot0_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> out_pc == $past(fetch_pc));

  p_last_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_offset == LAST) |=> out_valid == FETCH_W'(1));

  p_taken_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && grp_taken_end) |=> fetch_pc == ($past(pred_target) & AMASK));

  p_sequential_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !grp_taken_end) |=>
      fetch_pc == $past(fetch_pc) + (ADDR_W'($countones(out_valid)) << 2));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !redirect_valid) |=>
      $stable(fetch_pc) && $stable(out_valid) && $stable(out_insn) && $stable(out_pc));

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> out_valid == '0 && fetch_pc == ($past(redirect_pc) & AMASK));

  p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !redirect_valid && !cache_hit) |=> out_valid == '0 && $stable(fetch_pc));
endmodule

bind fetch_group_unit fetch_group_unit_chk #(
  .ADDR_W(ADDR_W), .WORDS(WORDS), .FETCH_W(FETCH_W), .INSN_W(fetch_pkg::INSN_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .cache_hit      (cache_hit),
  .out_ready      (out_ready),
  .pred_target    (pred_target),
  .fetch_pc       (fetch_pc),
  .out_valid      (out_valid),
  .out_insn       (out_insn),
  .out_pc         (out_pc),
  .issue          (issue),
  .grp_taken_end  (grp_taken_end),
  .grp_offset     (grp_offset)
);

// File: tb/fetch_group_unit_test.sv
`timescale 1ns/1ps
module fetch_group_unit_test;
  localparam int ADDR_W = 32;
  localparam int WORDS  = 8;
  localparam int FW     = 4;
  localparam int IW     = 32;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redirect_valid = 1'b0;
  logic [ADDR_W-1:0] redirect_pc = '0;
  logic [ADDR_W-1:0] fetch_pc;
  logic cache_hit = 1'b0;
  logic [WORDS*IW-1:0] cache_block = '0;
  logic [FW-1:0] pred_taken = '0;
  logic [ADDR_W-1:0] pred_target = '0;
  logic out_ready = 1'b0;
  logic [FW-1:0] out_valid;
  logic [FW*IW-1:0] out_insn;
  logic [ADDR_W-1:0] out_pc;

  fetch_group_unit #(.ADDR_W(ADDR_W), .WORDS(WORDS), .FETCH_W(FW), .RESET_PC(RPC)) uut (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fetch_pc(fetch_pc), .cache_hit(cache_hit), .cache_block(cache_block),
    .pred_taken(pred_taken), .pred_target(pred_target), .out_ready(out_ready),
    .out_valid(out_valid), .out_insn(out_insn), .out_pc(out_pc)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] exp_pc = RPC;
  logic [FW-1:0]     exp_valid = '0;
  logic [FW*IW-1:0]  exp_insn = '0;
  logic [ADDR_W-1:0] exp_outpc = '0;
  string tag_v = "R1", tag_pc = "R1", tag_i = "R1";

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag_v,  "out_valid", 256'(out_valid), 256'(exp_valid));
    chk(tag_pc, "fetch_pc",  256'(fetch_pc),  256'(exp_pc));
    chk(tag_i,  "out_insn",  256'(out_insn),  256'(exp_insn));
    chk(tag_i,  "out_pc",    256'(out_pc),    256'(exp_outpc));
  endtask

  // group length counted forward until a limit or a taken slot (R2)
  function automatic int grp_len(int off, logic [FW-1:0] tk, output bit te);
    int n = 0;
    te = 1'b0;
    while (n < FW && off + n < WORDS && !te) begin
      if (tk[n]) te = 1'b1;
      n++;
    end
    return n;
  endfunction

  task automatic step(bit rv, logic [31:0] rpc, bit rdy, bit hit,
                      logic [FW-1:0] tk, logic [31:0] tgt);
    int off, n;
    bit te;
    @(negedge clk);
    compare();
    redirect_valid = rv; redirect_pc = rpc; out_ready = rdy; cache_hit = hit;
    pred_taken = tk; pred_target = tgt;
    for (int k = 0; k < WORDS; k++) cache_block[k*IW +: IW] = $urandom;
    if (rv) begin
      exp_pc = rpc & ~32'd3; exp_valid = '0;
      tag_v = "R8"; tag_pc = "R8"; tag_i = "R8";
    end else if (!rdy) begin
      tag_v = "R7"; tag_pc = "R7"; tag_i = "R7";
    end else if (!hit) begin
      exp_valid = '0;
      tag_v = "R9"; tag_pc = "R9"; tag_i = "R9";
    end else begin
      off = int'(exp_pc[4:2]);
      n = grp_len(off, tk, te);
      exp_valid = FW'((1 << n) - 1);
      exp_insn = '0;
      for (int s = 0; s < n; s++) exp_insn[s*IW +: IW] = cache_block[(off+s)*IW +: IW];
      exp_outpc = exp_pc;
      exp_pc = te ? (tgt & ~32'd3) : exp_pc + 32'(4 * n);
      tag_v  = (off == WORDS-1) ? "R4" : (te ? "R5" : "R2");
      tag_pc = te ? "R5" : "R6";
      tag_i  = "R3";
    end
  endtask

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk("R1", "fetch_pc in reset", 256'(fetch_pc), 256'(RPC));
    chk("R1", "out_valid in reset", 256'(out_valid), 256'(0));
    rst_n = 1'b1;
    // directed corners
    step(1, 32'h2000_001D, 1, 0, 4'b0000, 32'h0);       // R8: offset 7, low bits dropped
    step(0, 0, 1, 1, 4'b0000, 32'h0);                   // R4: single slot at last word
    step(0, 0, 1, 1, 4'b0100, 32'h3000_0042);           // R5: taken at slot 2
    step(0, 0, 1, 1, 4'b0000, 32'h0);                   // R2/R6: full group
    step(1, 32'h4000_0018, 0, 0, 4'b0000, 32'h0);       // R8 with ready low, offset 6
    step(0, 0, 1, 1, 4'b1100, 32'h5000_0000);           // R2: taken beyond block ignored
    step(0, 0, 0, 1, 4'b0001, 32'h6000_0000);           // R7: stall
    step(0, 0, 1, 0, 4'b0000, 32'h0);                   // R9: miss
    step(0, 0, 1, 1, 4'b0001, 32'h7000_0010);           // R5: taken at slot 0
    for (int c = 0; c < 3000; c++) begin
      bit rv, rdy, hit;
      logic [FW-1:0] tk;
      rv  = ($urandom % 16) == 0;
      rdy = ($urandom % 6) != 0;
      hit = ($urandom % 8) != 0;
      for (int s = 0; s < FW; s++) tk[s] = ($urandom % 6) == 0;
      step(rv, $urandom, rdy, hit, tk, $urandom);
    end
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule